// File: doc/BRIEF.md
# Parallel ADC Conversion and Read Sequencer

This block is a synchronous controller for a 16-bit successive-approximation converter with a parallel output. The converter has two active-low control strobes, a select line (`adc_cs_n_o`) and a read/convert line (`adc_rc_n_o`), which it combines internally with an OR. A falling edge of the combined strobe starts a conversion. The converter also has a busy line that is low while it converts, and a half-swap line (`adc_bsel_o`) that exchanges the upper and lower bytes on its data pins.

A host requests one sample with a single-cycle `start_i` pulse. The controller then does five things in order:

1. It lowers read/convert while select stays high, then lowers select. The conversion therefore begins on the select edge.
2. It holds both strobes low for a programmed width, then releases them.
3. It waits for the busy line to go low and come back high.
4. It opens the outputs by lowering select with read/convert high, and waits a programmed access delay.
5. It samples the pins.

In word mode the full 16-bit bus is taken in one read. In byte mode only the lower eight pins are used, and they are read twice to build the word.

The word is returned on `data_o` with a one-cycle `valid_o` strobe. A converter that never finishes is cut off by a timeout.

Top module: `pconv_ctrl`

## Requirements
- R1: After reset, `adc_cs_n_o`, `adc_rc_n_o`, `busy_o`, `valid_o`, `timeout_o` and `adc_bsel_o` are in their idle state: both strobes high and every other output low. `data_o` is 0.
- R2: An accepted start drives `adc_rc_n_o` low for one cycle with `adc_cs_n_o` still high. It then drives `adc_cs_n_o` low, so each transaction has exactly one falling edge of the combined strobe. Both strobes stay low together for exactly STROBE_CYC cycles.
- R3: After the conversion strobe both strobes return high. The read does not begin until `adc_busy_n_i` (low = converting) has been seen low and then high again.
- R4: A read drives `adc_cs_n_o` low and `adc_rc_n_o` high. The bus is sampled only inside that window, after ACCESS_CYC cycles. In word mode there is one window of ACCESS_CYC cycles with `adc_bsel_o` low, and `data_o` takes all 16 pins.
- R5: In byte mode the lower eight pins are read twice inside one continuous window of 2×ACCESS_CYC cycles. The first read has `adc_bsel_o` high (lower pins carry bits 15..8) and the second has it low (lower pins carry bits 7..0). The result is {first, second}.
- R6: `valid_o` is high for exactly one cycle per result. `data_o` holds the 16-bit two's-complement code unchanged (0x7FFF, 0x8000, 0x0000 and others) until the next result.
- R7: `busy_o` is high from the cycle after an accepted start until the cycle in which `valid_o` or `timeout_o` pulses. In that cycle and while idle it is low, and both strobes are high.
- R8: A start pulse while `busy_o` is high is ignored. It causes no extra conversion edge and no extra `valid_o`.
- R9: If the busy handshake does not complete within TIMEOUT_CYC cycles of the wait, `timeout_o` pulses for one cycle without `valid_o`. The controller returns idle with both strobes high, and a later start works normally.
- R10: `byte_mode_i` is sampled only when a start is accepted. Changing it during a transaction does not change that transaction's read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request for a sample |
| byte_mode_i | input | 1 | 1 = two 8-bit reads on the lower pins, 0 = one 16-bit read |
| adc_busy_n_i | input | 1 | Converter busy, low while converting (synchronised inside) |
| adc_data_i | input | DATA_W | Converter data pins |
| adc_cs_n_o | output | 1 | Converter select strobe, active low |
| adc_rc_n_o | output | 1 | Converter read/convert strobe, low = convert |
| adc_bsel_o | output | 1 | Converter half-swap select |
| busy_o | output | 1 | Transaction in progress |
| valid_o | output | 1 | One-cycle result strobe |
| timeout_o | output | 1 | One-cycle busy-timeout flag |
| data_o | output | DATA_W | Last captured result |

## Verification
The checks assume two things about the converter. First, it pulls its busy line low only after a falling edge of the combined strobe, and raises it once when the result is latched. Second, its pins are stable no later than ACCESS_CYC cycles after the outputs open or the half-swap line changes. The checks also assume that the host issues `start_i` as a pulse.

The bench converter model lowers busy on the negative clock edge that follows the combined strobe edge, and raises it a fixed number of cycles later. It drives the bus combinationally from the strobes and the swap line, and floats the bus outside a read. If the controller samples outside a read, the result is therefore unknown. In its stuck mode the model never answers, which is how the bench produces the timeout.

// File: rtl/pconv_pkg.sv
package pconv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_CONV,
        ST_WAIT,
        ST_RDA,
        ST_RDB
    } pconv_st_e;
endpackage

// File: rtl/pconv_sync.sv
module pconv_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic out_o
);
    logic [STAGES-1:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], in_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
        else        sh_q <= sh_d;
    end

    assign out_o = sh_q[STAGES-1];
endmodule

// File: rtl/pconv_timer.sv
module pconv_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R2
    hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/pconv_wdog.sv
module pconv_wdog #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic expired_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!en_i)              cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = en_i && (cnt_q == LAST);

    // R9
    wdog_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !expired_o || (LIMIT == 1));
endmodule

// File: rtl/pconv_ctrl.sv
module pconv_ctrl
    import pconv_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int STROBE_CYC  = 4,
    parameter int ACCESS_CYC  = 3,
    parameter int TIMEOUT_CYC = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              byte_mode_i,
    input  logic              adc_busy_n_i,
    input  logic [DATA_W-1:0] adc_data_i,
    output logic              adc_cs_n_o,
    output logic              adc_rc_n_o,
    output logic              adc_bsel_o,
    output logic              busy_o,
    output logic              valid_o,
    output logic              timeout_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int BYTE_W = DATA_W / 2;
    localparam int TMAX   = (STROBE_CYC > ACCESS_CYC) ? STROBE_CYC : ACCESS_CYC;
    localparam int TW     = $clog2(TMAX + 1);

    typedef struct packed {
        pconv_st_e         st;
        logic              cs_n;
        logic              rc_n;
        logic              bsel;
        logic              bmode;
        logic              seen_low;
        logic              busy;
        logic              valid;
        logic              tout;
        logic [BYTE_W-1:0] hi;
        logic [DATA_W-1:0] data;
    } regs_t;

    localparam regs_t REGS_RST = '{st: ST_IDLE, cs_n: 1'b1, rc_n: 1'b1, bsel: 1'b0,
                                   bmode: 1'b0, seen_low: 1'b0, busy: 1'b0,
                                   valid: 1'b0, tout: 1'b0, hi: '0, data: '0};

    regs_t r_q, r_d;
    logic  busy_s;
    logic  t_load, t_zero, wd_exp, sample;
    logic [TW-1:0] t_val;

    pconv_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) busy_sync_i (
        .clk(clk), .rst_n(rst_n), .in_i(adc_busy_n_i), .out_o(busy_s));

    pconv_timer #(.W(TW)) phase_tmr_i (
        .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val), .zero_o(t_zero));

    pconv_wdog #(.LIMIT(TIMEOUT_CYC)) busy_wdog_i (
        .clk(clk), .rst_n(rst_n), .en_i(r_q.st == ST_WAIT), .expired_o(wd_exp));

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        r_d.tout  = 1'b0;
        t_load    = 1'b0;
        t_val     = '0;
        sample    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st       = ST_ARM;
                    r_d.bmode    = byte_mode_i;
                    r_d.seen_low = 1'b0;
                end
            end
            ST_ARM: begin
                r_d.st = ST_CONV;
                t_load = 1'b1;
                t_val  = TW'(STROBE_CYC - 1);
            end
            ST_CONV: begin
                if (!busy_s) r_d.seen_low = 1'b1;
                if (t_zero)  r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (!busy_s) r_d.seen_low = 1'b1;
                if (r_q.seen_low && busy_s) begin
                    r_d.st = ST_RDA;
                    t_load = 1'b1;
                    t_val  = TW'(ACCESS_CYC - 1);
                end else if (wd_exp) begin
                    r_d.st   = ST_IDLE;
                    r_d.tout = 1'b1;
                end
            end
            ST_RDA: begin
                if (t_zero) begin
                    sample = 1'b1;
                    if (r_q.bmode) begin
                        r_d.hi = adc_data_i[BYTE_W-1:0];
                        r_d.st = ST_RDB;
                        t_load = 1'b1;
                        t_val  = TW'(ACCESS_CYC - 1);
                    end else begin
                        r_d.data  = adc_data_i;
                        r_d.valid = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
            end
            ST_RDB: begin
                if (t_zero) begin
                    sample    = 1'b1;
                    r_d.data  = {r_q.hi, adc_data_i[BYTE_W-1:0]};
                    r_d.valid = 1'b1;
                    r_d.st    = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        r_d.cs_n = !(r_d.st inside {ST_CONV, ST_RDA, ST_RDB});
        r_d.rc_n = !(r_d.st inside {ST_ARM, ST_CONV});
        r_d.bsel = (r_d.st == ST_RDA) && r_d.bmode;
        r_d.busy = (r_d.st != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end

    assign adc_cs_n_o = r_q.cs_n;
    assign adc_rc_n_o = r_q.rc_n;
    assign adc_bsel_o = r_q.bsel;
    assign busy_o     = r_q.busy;
    assign valid_o    = r_q.valid;
    assign timeout_o  = r_q.tout;
    assign data_o     = r_q.data;

    // R7
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (adc_cs_n_o && adc_rc_n_o));
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R9
    tout_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!valid_o && !busy_o));
    // R4
    sample_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (!adc_cs_n_o && adc_rc_n_o));
    // R2
    conv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_rc_n_o) |-> adc_cs_n_o);
    // R5
    bsel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_bsel_o |-> (!adc_cs_n_o && adc_rc_n_o));
    // R8
    start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !valid_o && !timeout_o) |=> busy_o || valid_o || timeout_o);
endmodule

// File: tb/pconv_ctrl_tb.sv
module pconv_ctrl_tb_top;
    localparam int STB  = 3;
    localparam int ACC  = 2;
    localparam int TMO  = 40;
    localparam int CONV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bmode = 1'b0;
    logic        mdl_busy_n;
    logic [15:0] adc_d;
    logic        cs_n, rc_n, bsel, busy, valid, tout;
    logic [15:0] dout;

    int tests = 0, fails = 0;
    logic        dead = 1'b0;
    logic [15:0] code_in = '0;
    logic [15:0] m_out = '0, m_latch = '0;
    int          m_cnt = 0;
    logic        m_pconv = 1'b1;

    int conv_cnt = 0, order_bad = 0, lowrun = 0, last_low = 0;
    int rd_bad = 0, rdrun = 0, last_rd = 0, valid_cnt = 0, to_cnt = 0, bsel_cnt = 0;
    logic p_conv = 1'b1, p_cs = 1'b1, p_rc = 1'b1, p_rd = 1'b0;

    always #5 clk = ~clk;

    pconv_ctrl #(.DATA_W(16), .STROBE_CYC(STB), .ACCESS_CYC(ACC),
                 .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .byte_mode_i(bmode),
        .adc_busy_n_i(mdl_busy_n), .adc_data_i(adc_d),
        .adc_cs_n_o(cs_n), .adc_rc_n_o(rc_n), .adc_bsel_o(bsel),
        .busy_o(busy), .valid_o(valid), .timeout_o(tout), .data_o(dout));

    // converter model
    assign adc_d = (!cs_n && rc_n) ? (bsel ? {m_out[7:0], m_out[15:8]} : m_out) : 16'hzzzz;

    always @(negedge clk) begin
        if (!rst_n) begin
            mdl_busy_n <= 1'b1;
            m_cnt   = 0;
            m_pconv = 1'b1;
        end else begin
            if (m_pconv && !(cs_n | rc_n) && !dead) begin
                mdl_busy_n <= 1'b0;
                m_latch = code_in;
                m_cnt   = CONV;
            end else if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_out = m_latch;
                    mdl_busy_n <= 1'b1;
                end
            end
            m_pconv = cs_n | rc_n;
        end
    end

    // port monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_conv && !(cs_n | rc_n)) begin
                conv_cnt++;
                if (!(p_rc == 1'b0 && p_cs == 1'b1)) order_bad++;
            end
            if (!(cs_n | rc_n)) lowrun++;
            else if (!p_conv) begin last_low = lowrun; lowrun = 0; end
            if (!cs_n && rc_n) begin
                if (!p_rd && !mdl_busy_n) rd_bad++;
                rdrun++;
            end else if (p_rd) begin last_rd = rdrun; rdrun = 0; end
            if (valid) valid_cnt++;
            if (tout)  to_cnt++;
            if (bsel)  bsel_cnt++;
            p_conv = cs_n | rc_n;
            p_cs = cs_n; p_rc = rc_n; p_rd = !cs_n && rc_n;
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_start(input logic bm);
        bmode = bm;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic wait_end(input int v0, input int t0);
        for (int i = 0; i < 400; i++) begin
            if (valid_cnt != v0 || to_cnt != t0) break;
            tick();
        end
    endtask

    task automatic t_reset();
        chk("R1 cs_n", cs_n, 1); chk("R1 rc_n", rc_n, 1); chk("R1 bsel", bsel, 0);
        chk("R1 busy", busy, 0); chk("R1 valid", valid, 0); chk("R1 tout", tout, 0);
        chk("R1 data", dout, 0);
    endtask

    task automatic run_one(input logic [15:0] code, input logic bm);
        int v0 = valid_cnt, t0 = to_cnt, c0 = conv_cnt, b0 = bsel_cnt;
        code_in = code;
        pulse_start(bm);
        chk("R7 busy after start", busy, 1);
        wait_end(v0, t0);
        chk("R6 one valid", valid_cnt - v0, 1);
        chk("R7 busy low at valid", busy, 0);
        chk(bm ? "R5 byte data" : "R4 word data", dout, code);
        chk("R2 one conversion", conv_cnt - c0, 1);
        chk("R2 strobe width", last_low, STB);
        chk("R2 order", order_bad, 0);
        chk("R3 read after busy", rd_bad, 0);
        chk(bm ? "R5 window" : "R4 window", last_rd, bm ? 2 * ACC : ACC);
        chk(bm ? "R5 bsel cycles" : "R4 bsel low", bsel_cnt - b0, bm ? ACC : 0);
        tick();
        chk("R6 valid drops", valid, 0);
        chk("R6 data held", dout, code);
    endtask

    task automatic t_ignore();
        int v0 = valid_cnt, t0 = to_cnt, c0 = conv_cnt, b0 = bsel_cnt;
        code_in = 16'h2468;
        pulse_start(1'b0);
        tick();
        pulse_start(1'b1);
        repeat (6) tick();
        pulse_start(1'b1);
        bmode = 1'b0;
        wait_end(v0, t0);
        chk("R8 single conversion", conv_cnt - c0, 1);
        chk("R8 single valid", valid_cnt - v0, 1);
        chk("R10 mode kept word", bsel_cnt - b0, 0);
        chk("R10 data", dout, 16'h2468);
        repeat (5) tick();
        chk("R8 no extra valid", valid_cnt - v0, 1);
        chk("R8 idle after", busy, 0);
    endtask

    task automatic t_timeout();
        int v0 = valid_cnt, t0 = to_cnt;
        logic [15:0] prev = dout;
        dead = 1'b1;
        pulse_start(1'b0);
        wait_end(v0, t0);
        chk("R9 timeout pulse", to_cnt - t0, 1);
        chk("R9 no valid", valid_cnt - v0, 0);
        chk("R9 busy low", busy, 0);
        chk("R9 strobes high", {cs_n, rc_n}, 2'b11);
        chk("R9 data kept", dout, prev);
        tick();
        chk("R9 pulse one cycle", tout, 0);
        dead = 1'b0;
        repeat (3) tick();
        run_one(16'h0F0F, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        repeat (3) tick();
        t_reset();
        run_one(16'h7FFF, 1'b0);
        run_one(16'h8000, 1'b0);
        run_one(16'h0000, 1'b0);
        run_one(16'h1234, 1'b0);
        run_one(16'hA55A, 1'b1);
        run_one(16'h00FF, 1'b1);
        run_one(16'h8001, 1'b1);
        t_ignore();
        t_timeout();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule